// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is one DMA channel that copies a series of buffers by following a chain of descriptors kept in memory. Each descriptor is five consecutive 32-bit words:

| Offset | Word |
|---|---|
| +0 | source address |
| +4 | destination address |
| +8 | control A |
| +12 | control B |
| +16 | next-descriptor pointer |

The engine reads all five words, then copies the buffer one word at a time. Each word is a read from the source followed by a write to the destination. When the buffer is done, the engine writes control A back with its completion flag set. It then moves to the next descriptor, or stops if the next pointer is zero.

Software loads the head pointer, turns on the global enable, and sets the channel enable. The hardware clears the channel enable when the chain ends. A single word-wide memory master port carries both the descriptor traffic and the data moves.

Each side of the copy is paced in one of two ways:
- hardware pacing, through a request/acknowledge wire pair;
- software pacing, through request bits written into a register.

Copies are grouped into transactions of either one word or a chunk of several words. Two one-cycle interrupt pulses mark the end of each buffer and the end of the whole chain. Each pulse also sets a sticky status bit, which software clears by writing a 1 to it.

Top module: `ll_dma_chan`

## Requirements
- R1: The channel leaves idle only when both conditions hold: the channel enable bit (command register, address 2, write bit 0) has been set, and the global enable (address 0, bit 0) is 1. Until then the engine makes no memory access.
- R2: A descriptor fetch reads the five words at byte addresses ptr, ptr+4, ptr+8, ptr+12 and ptr+16, in that order. The first fetch uses the head pointer register (address 1).
- R3: For a buffer of length L, the engine makes L read/write pairs. L is taken from control A bits [15:0]. The source address steps by the mode in control B bits [1:0], and the destination address by the mode in bits [3:2]. Mode codes: 0 adds 4, 1 subtracts 4, 2 holds the address.
- R4: After a buffer, the engine writes control A back to ptr+8 with bit 31 set. All other bits keep their fetched values.
- R5: A descriptor with length 0 makes no data move. It still does the write-back and gives the buffer-complete pulse.
- R6: A next pointer that is not zero starts a fetch at that address. A zero next pointer ends the chain, as follows:
  - the transfer-complete pulse fires together with the last buffer-complete pulse;
  - the channel enable (status bit 0) clears;
  - the engine returns to idle.
- R7: The pulses behave as follows:
  - buf_irq gives one one-cycle pulse per descriptor;
  - xfer_irq gives one one-cycle pulse per chain;
  - each pulse sets its sticky status bit: bit 1 for buffer complete, bit 2 for transfer complete;
  - writing 1 to a sticky bit at address 3 clears it.
- R8: The pacing mode of each side is chosen in control B: bit 4 for the source, bit 5 for the destination. A 1 selects hardware pacing, where src_req/dst_req must be high. A 0 selects software pacing, where a pending request must exist; command bit 1 sets the source request and bit 2 sets the destination request. No transaction starts until both sides permit it.
- R9: Control B bit 6 selects the transaction size. A 1 selects a chunk of CHUNK words, or fewer if fewer remain. A 0 selects a single word. At the end of each transaction, every hardware-paced side receives one ack pulse, and every software-paced side has its pending request cleared (status bits 3 and 4).
- R10: After reset the engine is idle, with no memory request and no pulses, and all status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 2 | register select |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| mem_req | output | 1 | memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | byte address, word aligned |
| mem_wdata | output | 32 | write data |
| mem_rdata | input | 32 | read data, valid with mem_ack |
| mem_ack | input | 1 | access completes this cycle |
| src_req | input | 1 | source peripheral request (hardware pacing) |
| src_ack | output | 1 | source transaction acknowledge pulse |
| dst_req | input | 1 | destination peripheral request (hardware pacing) |
| dst_ack | output | 1 | destination transaction acknowledge pulse |
| buf_irq | output | 1 | buffer-complete pulse |
| xfer_irq | output | 1 | transfer-complete pulse |

## Verification
The copy path is swept over a two-descriptor chain. The first descriptor covers every pair of source and destination address modes, lengths 0 to 5, and both transaction sizes, so the sweep separates the effects of increment, decrement and hold on each side independently. Running the lengths against a chunk of 2 produces both full and remainder chunks, which the acknowledge counts distinguish. Length 0 isolates the write-back-only path.

Directed runs hold back each pacing source in turn. The gating tests separate three cases: a missing hardware request, a missing software request, and a missing global enable.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_WAIT, S_RD, S_WR, S_WB
    } dma_st_e;

    // control B bit positions
    localparam int CB_SRC_MODE = 0;
    localparam int CB_DST_MODE = 2;
    localparam int CB_SRC_HW   = 4;
    localparam int CB_DST_HW   = 5;
    localparam int CB_CHUNK    = 6;
    localparam int CB_BITS     = 7;
    // control A completion flag
    localparam int CA_DONE     = 31;

    // address step modes
    localparam logic [1:0] M_INC = 2'd0;
    localparam logic [1:0] M_DEC = 2'd1;

    // register selects
    localparam logic [1:0] RA_GLOBAL = 2'd0;
    localparam logic [1:0] RA_HEAD   = 2'd1;
    localparam logic [1:0] RA_CMD    = 2'd2;
    localparam logic [1:0] RA_STAT   = 2'd3;
endpackage

// File: rtl/ll_dma_step.sv
module ll_dma_step #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    mode,
    output logic [AW-1:0] next
);
    import ll_dma_pkg::*;

    always_comb begin
        case (mode)
            M_INC:   next = addr + AW'(STEP);
            M_DEC:   next = addr - AW'(STEP);
            default: next = addr;
        endcase
    end
endmodule

// File: rtl/ll_dma_regs.sv
module ll_dma_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        fin,
    input  logic        buf_ev,
    input  logic        xfer_ev,
    input  logic        clr_src,
    input  logic        clr_dst,
    output logic        start,
    output logic [31:0] head,
    output logic        sw_src,
    output logic        sw_dst
);
    import ll_dma_pkg::*;

    typedef struct packed {
        logic        glob;
        logic [31:0] head;
        logic        en;
        logic        bsti;
        logic        xsti;
        logic        sws;
        logic        swd;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // hardware clears first, software writes after (set wins)
        if (fin)     r_d.en  = 1'b0;
        if (clr_src) r_d.sws = 1'b0;
        if (clr_dst) r_d.swd = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                RA_GLOBAL: r_d.glob = reg_wdata[0];
                RA_HEAD:   r_d.head = reg_wdata;
                RA_CMD: begin
                    if (reg_wdata[0]) r_d.en  = 1'b1;
                    if (reg_wdata[1]) r_d.sws = 1'b1;
                    if (reg_wdata[2]) r_d.swd = 1'b1;
                end
                default: begin
                    if (reg_wdata[1]) r_d.bsti = 1'b0;
                    if (reg_wdata[2]) r_d.xsti = 1'b0;
                end
            endcase
        end
        if (buf_ev)  r_d.bsti = 1'b1;
        if (xfer_ev) r_d.xsti = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr)
            RA_GLOBAL: reg_rdata = {31'd0, r_q.glob};
            RA_HEAD:   reg_rdata = r_q.head;
            RA_STAT:   reg_rdata = {27'd0, r_q.swd, r_q.sws, r_q.xsti, r_q.bsti, r_q.en};
            default:   reg_rdata = 32'd0;
        endcase
    end

    assign start  = r_q.en & r_q.glob;
    assign head   = r_q.head;
    assign sw_src = r_q.sws;
    assign sw_dst = r_q.swd;

    AST_BUF_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bsti && !(reg_we && reg_addr == RA_STAT && reg_wdata[1]) |=> r_q.bsti); // R7
    AST_EN_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !r_q.en); // R6
endmodule

// File: rtl/ll_dma_fsm.sv
module ll_dma_fsm #(
    parameter int CHUNK = 4,
    parameter int LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] head,
    input  logic        sw_src,
    input  logic        sw_dst,
    output logic        fin,
    output logic        clr_src,
    output logic        clr_dst,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    input  logic        src_req,
    output logic        src_ack,
    input  logic        dst_req,
    output logic        dst_ack,
    output logic        buf_irq,
    output logic        xfer_irq
);
    import ll_dma_pkg::*;

    localparam int GW = $clog2(CHUNK + 1);

    typedef struct packed {
        dma_st_e             st;
        logic [2:0]          fidx;
        logic [31:0]         ptr;
        logic [31:0]         sa;
        logic [31:0]         da;
        logic [31:0]         ctla;
        logic [31:0]         nxt;
        logic [31:0]         data;
        logic [CB_BITS-1:0]  ctlb;
        logic [LEN_W-1:0]    len;
        logic [GW-1:0]       grp;
        logic                sack;
        logic                dack;
        logic                birq;
        logic                xirq;
    } fsm_t;

    fsm_t f_d, f_q;
    logic [31:0] sa_next, da_next;
    logic        hw_s, hw_d, go;

    ll_dma_step u_src_step (.addr(f_q.sa), .mode(f_q.ctlb[CB_SRC_MODE +: 2]), .next(sa_next));
    ll_dma_step u_dst_step (.addr(f_q.da), .mode(f_q.ctlb[CB_DST_MODE +: 2]), .next(da_next));

    assign hw_s = f_q.ctlb[CB_SRC_HW];
    assign hw_d = f_q.ctlb[CB_DST_HW];
    assign go   = (hw_s ? src_req : sw_src) && (hw_d ? dst_req : sw_dst);

    always_comb begin
        f_d       = f_q;
        f_d.sack  = 1'b0;
        f_d.dack  = 1'b0;
        f_d.birq  = 1'b0;
        f_d.xirq  = 1'b0;
        fin       = 1'b0;
        clr_src   = 1'b0;
        clr_dst   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = 32'd0;
        mem_wdata = 32'd0;
        case (f_q.st)
            S_IDLE: begin
                if (start) begin
                    f_d.ptr  = head;
                    f_d.fidx = 3'd0;
                    f_d.st   = S_FETCH;
                end
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = f_q.ptr + {27'd0, f_q.fidx, 2'b00};
                if (mem_ack) begin
                    case (f_q.fidx)
                        3'd0:    f_d.sa   = mem_rdata;
                        3'd1:    f_d.da   = mem_rdata;
                        3'd2:    f_d.ctla = mem_rdata;
                        3'd3:    f_d.ctlb = mem_rdata[CB_BITS-1:0];
                        default: f_d.nxt  = mem_rdata;
                    endcase
                    if (f_q.fidx == 3'd4) begin
                        f_d.len = f_q.ctla[LEN_W-1:0];
                        f_d.st  = (f_q.ctla[LEN_W-1:0] == '0) ? S_WB : S_WAIT;
                    end else begin
                        f_d.fidx = f_q.fidx + 3'd1;
                    end
                end
            end
            S_WAIT: begin
                if (go) begin
                    if (!f_q.ctlb[CB_CHUNK])
                        f_d.grp = GW'(1);
                    else if (f_q.len >= LEN_W'(CHUNK))
                        f_d.grp = GW'(CHUNK);
                    else
                        f_d.grp = GW'(f_q.len);
                    f_d.st = S_RD;
                end
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = f_q.sa;
                if (mem_ack) begin
                    f_d.data = mem_rdata;
                    f_d.st   = S_WR;
                end
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = f_q.da;
                mem_wdata = f_q.data;
                if (mem_ack) begin
                    f_d.sa  = sa_next;
                    f_d.da  = da_next;
                    f_d.len = f_q.len - LEN_W'(1);
                    f_d.grp = f_q.grp - GW'(1);
                    if (f_q.grp == GW'(1)) begin
                        f_d.sack = hw_s;
                        f_d.dack = hw_d;
                        clr_src  = !hw_s;
                        clr_dst  = !hw_d;
                        f_d.st   = (f_q.len == LEN_W'(1)) ? S_WB : S_WAIT;
                    end else begin
                        f_d.st = S_RD;
                    end
                end
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = f_q.ptr + 32'd8;
                mem_wdata = f_q.ctla | (32'd1 << CA_DONE);
                if (mem_ack) begin
                    f_d.birq = 1'b1;
                    if (f_q.nxt == 32'd0) begin
                        f_d.xirq = 1'b1;
                        fin      = 1'b1;
                        f_d.st   = S_IDLE;
                    end else begin
                        f_d.ptr  = f_q.nxt;
                        f_d.fidx = 3'd0;
                        f_d.st   = S_FETCH;
                    end
                end
            end
            default: f_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign src_ack  = f_q.sack;
    assign dst_ack  = f_q.dack;
    assign buf_irq  = f_q.birq;
    assign xfer_irq = f_q.xirq;

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.st == S_IDLE |-> !mem_req); // R1
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R2
    AST_SRC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.st == S_WAIT && hw_s && !src_req |=> f_q.st != S_RD); // R8
    AST_XFER_WITH_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_irq |-> buf_irq && f_q.st == S_IDLE); // R6
    AST_BUF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_irq |=> !buf_irq); // R7
endmodule

// File: rtl/ll_dma_chan.sv
module ll_dma_chan #(
    parameter int CHUNK = 4,
    parameter int LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    input  logic        src_req,
    output logic        src_ack,
    input  logic        dst_req,
    output logic        dst_ack,
    output logic        buf_irq,
    output logic        xfer_irq
);
    logic        start, fin, clr_src, clr_dst, sw_src, sw_dst;
    logic [31:0] head;

    ll_dma_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fin(fin), .buf_ev(buf_irq), .xfer_ev(xfer_irq),
        .clr_src(clr_src), .clr_dst(clr_dst),
        .start(start), .head(head), .sw_src(sw_src), .sw_dst(sw_dst)
    );

    ll_dma_fsm #(.CHUNK(CHUNK), .LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(start), .head(head), .sw_src(sw_src), .sw_dst(sw_dst),
        .fin(fin), .clr_src(clr_src), .clr_dst(clr_dst),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .src_req(src_req), .src_ack(src_ack), .dst_req(dst_req), .dst_ack(dst_ack),
        .buf_irq(buf_irq), .xfer_irq(xfer_irq)
    );
endmodule

// File: tb/sim_ll_dma_chan.sv
`timescale 1ns/1ps
module sim_ll_dma_chan;
    localparam int CH = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, reg_we;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        src_req, src_ack, dst_req, dst_ack, buf_irq, xfer_irq;

    ll_dma_chan #(.CHUNK(CH)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .src_req(src_req), .src_ack(src_ack), .dst_req(dst_req), .dst_ack(dst_ack),
        .buf_irq(buf_irq), .xfer_irq(xfer_irq)
    );

    logic [31:0] mem [256];
    logic [31:0] expm [256];
    int rd_cnt = 0, wr_cnt = 0;
    int nbuf = 0, nxfer = 0, nsack = 0, ndack = 0;
    int total = 0, bad = 0;
    bit finished = 0;

    // memory model: one wait cycle, ack for one cycle
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[9:2]] <= mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata <= mem[mem_addr[9:2]];
                    rd_cnt++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (buf_irq)  nbuf++;
        if (xfer_irq) nxfer++;
        if (src_ack)  nsack++;
        if (dst_ack)  ndack++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic int stp(input int m);
        return (m == 0) ? 1 : (m == 1) ? -1 : 0;
    endfunction

    function automatic int ntr(input int l, input int c);
        return (c != 0) ? (l + CH - 1) / CH : l;
    endfunction

    // descriptor 0 at byte 0, descriptor 1 at byte 0x20; expected image computed
    task automatic setup(input int sm, input int dm, input int len, input int ck,
                         input int hs, input int hd);
        logic [31:0] cb0, cb1, ca0, ca1;
        for (int i = 0; i < 256; i++)
            mem[i] = (i >= 64 && i < 128) ? (32'hC0DE0000 + 32'(i) * 32'h101) : 32'd0;
        ca0 = {1'b0, 15'h1234, 16'(len)};
        ca1 = {1'b0, 15'h0567, 16'd2};
        cb0 = 32'(ck << 6 | hd << 5 | hs << 4 | dm << 2 | sm);
        cb1 = 32'(ck << 6 | hd << 5 | hs << 4);
        mem[0] = 32'd72 * 4;  mem[1] = 32'd140 * 4; mem[2]  = ca0; mem[3]  = cb0; mem[4]  = 32'h20;
        mem[8] = 32'd100 * 4; mem[9] = 32'd160 * 4; mem[10] = ca1; mem[11] = cb1; mem[12] = 32'd0;
        for (int i = 0; i < 256; i++) expm[i] = mem[i];
        for (int i = 0; i < len; i++) expm[140 + stp(dm) * i] = mem[72 + stp(sm) * i];
        for (int i = 0; i < 2; i++) expm[160 + i] = mem[100 + i];
        expm[2]  = ca0 | 32'h8000_0000;
        expm[10] = ca1 | 32'h8000_0000;
    endtask

    task automatic run_wait(input int hs, input int hd);
        logic [31:0] st;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd3, st);
            if (!st[0]) break;
            if (hs == 0 && !st[3]) wr(2'd2, 32'd2);
            if (hd == 0 && !st[4]) wr(2'd2, 32'd4);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R6 act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] st;
        int r0, w0, b0, x0, s0, d0, mism;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 32'd0;
        src_req = 1'b0; dst_req = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(2'd3, st);
        chk("R10 status after reset", st, 32'd0);
        chk("R10 no memory request", {31'd0, mem_req}, 32'd0);
        chk("R10 no pulses", {30'd0, buf_irq, xfer_irq}, 32'd0);

        // R1: channel enable without global enable does nothing
        setup(0, 0, 1, 0, 1, 1);
        src_req = 1'b1; dst_req = 1'b1;
        r0 = rd_cnt; b0 = nbuf;
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd1);
        repeat (30) @(negedge clk);
        chk("R1 no access without global enable", 32'(rd_cnt - r0), 32'd0);
        rd(2'd3, st);
        chk("R1 channel enable bit held", {31'd0, st[0]}, 32'd1);
        wr(2'd0, 32'd1);
        run_wait(1, 1);
        chk("R1 chain runs once global enable set", 32'(nbuf - b0), 32'd2);
        wr(2'd3, 32'd6);

        // R8: gating by hardware then software request
        setup(0, 0, 3, 0, 1, 0);
        src_req = 1'b0; dst_req = 1'b0;
        r0 = rd_cnt; s0 = nsack;
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd1);
        repeat (40) @(negedge clk);
        chk("R8 no move without hw source request", 32'(rd_cnt - r0), 32'd5);
        src_req = 1'b1;
        repeat (30) @(negedge clk);
        chk("R8 no move without sw destination request", 32'(rd_cnt - r0), 32'd5);
        wr(2'd2, 32'd4);
        repeat (30) @(negedge clk);
        chk("R9 single transaction moves one word", 32'(rd_cnt - r0), 32'd6);
        chk("R9 one ack per single transaction", 32'(nsack - s0), 32'd1);
        rd(2'd3, st);
        chk("R9 sw pending cleared after transaction", {31'd0, st[4]}, 32'd0);
        run_wait(1, 0);
        wr(2'd3, 32'd6);

        // sweep: all mode pairs, lengths 0..5, single and chunk
        for (int sm = 0; sm < 3; sm++)
            for (int dm = 0; dm < 3; dm++)
                for (int len = 0; len < 6; len++)
                    for (int ck = 0; ck < 2; ck++) begin
                        int hs, hd;
                        hs = (len + dm) % 2;
                        hd = ((len >> 1) + sm + ck) % 2;
                        setup(sm, dm, len, ck, hs, hd);
                        src_req = hs[0]; dst_req = hd[0];
                        r0 = rd_cnt; w0 = wr_cnt; b0 = nbuf; x0 = nxfer; s0 = nsack; d0 = ndack;
                        wr(2'd1, 32'd0);
                        wr(2'd2, 32'd1);
                        run_wait(hs, hd);
                        mism = 0;
                        for (int i = 0; i < 256; i++)
                            if (mem[i] !== expm[i]) mism++;
                        chk($sformatf("R3 image s%0d d%0d l%0d c%0d", sm, dm, len, ck), 32'(mism), 32'd0);
                        chk("R4 done write-back first", mem[2], expm[2]);
                        chk("R4 done write-back second", mem[10], expm[10]);
                        chk($sformatf("R2/R5 reads l%0d", len), 32'(rd_cnt - r0), 32'(10 + len + 2));
                        chk($sformatf("R5 writes l%0d", len), 32'(wr_cnt - w0), 32'(len + 2 + 2));
                        chk("R7 buffer pulses", 32'(nbuf - b0), 32'd2);
                        chk("R6 transfer pulses", 32'(nxfer - x0), 32'd1);
                        chk($sformatf("R9 src acks l%0d c%0d", len, ck), 32'(nsack - s0),
                            32'(hs != 0 ? ntr(len, ck) + ntr(2, ck) : 0));
                        chk($sformatf("R9 dst acks l%0d c%0d", len, ck), 32'(ndack - d0),
                            32'(hd != 0 ? ntr(len, ck) + ntr(2, ck) : 0));
                        rd(2'd3, st);
                        chk("R6 enable cleared, R7 sticky set", {29'd0, st[2:0]}, 32'd6);
                        wr(2'd3, 32'd6);
                        rd(2'd3, st);
                        chk("R7 sticky bits cleared by write-1", {29'd0, st[2:0]}, 32'd0);
                    end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule